// File: doc/BRIEF.md
# Page-Buffered Flash Programming Controller

This block sits between a CPU and a small behavioural nonvolatile store. The CPU first fills a page-sized latch buffer one byte at a time. It then launches programming with a two-write unlock. A controller then moves the loaded bytes into one of three target spaces: the main user array, a single extra row the size of one page, or a one-byte fuse location. Only the bytes that were loaded are erased and rewritten. Every other location keeps its old value, so no separate page erase is needed.

The CPU sees one control/status register and two byte ports. The write port feeds the latch buffer. The read port returns bytes from the currently selected space. A cycle counter models the programming time. A busy flag covers that whole time, and the byte ports are closed off while it is set.

The control write byte is laid out as follows:

- bits 7:4 hold the launch key;
- bit 3 is the latch-map enable;
- bits 2:1 hold the space select;
- bit 0 is ignored.

A status read returns `{4'b0, map, space[1:0], busy}`.

Top module: `flash_page_prog`

## Requirements
- R1: After reset the status byte reads 00h: map clear, space 00, busy clear. The stored contents are not disturbed by reset; an unprogrammed location reads FFh.
- R2: A latch write is taken only while the map bit (status bit 3) is set and busy is clear. The low log2(PAGE_BYTES) address bits pick the byte, and the bits above them pick the page. The page of the most recent accepted latch write is the one programmed.
- R3: A control write with key 5h, followed by a control write with key Ah whose bits 3:1 equal those of the 5h write, starts programming. Busy reads 1 in the cycle after the Ah write.
- R4: Any control write other than the expected next unlock step clears the unlock state, so no programming starts. This covers an Ah with no armed 5h before it, a different key between the two, and a change of bits 3:1 between them.
- R5: Space select 00 targets the user array, 01 the extra row and 10 the fuse byte. Space select 11 never starts programming, even after a correct unlock.
- R6: Busy stays set for exactly max(PROG_CYCLES, PAGE_BYTES+2) clock cycles and then clears by itself.
- R7: Programming rewrites only the latch bytes loaded since the last programming. All other bytes of the target page keep their previous values.
- R8: The per-byte loaded marks are cleared when programming ends. A later launch writes only the bytes loaded after that point.
- R9: With space 01, loaded byte i is written to extra-row byte i. The user array is untouched.
- R10: With space 10, bits 7:4 of latch byte 0 replace bits 7:4 of the fuse byte. Bits 3:0 of the fuse byte can never be changed from the CPU side.
- R11: A read returns the byte of the space selected at that time one cycle later, flagged by rd_valid. Space 11 reads FFh, and any read issued while busy returns FFh.
- R12: While busy, latch writes and control writes are ignored. Neither the page contents nor the loaded marks nor the status change because of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write: key[7:4], map[3], space[2:1] |
| ctl_rdata | output | 8 | Status: {0000, map, space, busy} |
| lat_we | input | 1 | Latch byte write strobe |
| lat_addr | input | AW | Latch write address {page, byte} |
| lat_wdata | input | 8 | Latch write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address in the selected space |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The bench builds the block with 16-byte pages, 4 pages and a 40-cycle programming time. These values make the six-bit address and the page and byte split easy to set by hand, and they give a short busy window that can be counted exactly. Because the page is small, the bench can fill whole pages, check bytes left untouched beside loaded ones, and catch stale loaded marks across several back-to-back launches within a few hundred cycles. The short window also leaves room to put ignored latch, control and read traffic inside a single busy period.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  typedef enum logic [1:0] {
    SP_USER = 2'b00,
    SP_XROW = 2'b01,
    SP_FUSE = 2'b10,
    SP_NONE = 2'b11
  } space_e;

  localparam logic [3:0] KEY_ARM = 4'h5;
  localparam logic [3:0] KEY_GO  = 4'hA;
endpackage

// File: rtl/fpp_unlock.sv
module fpp_unlock
  import fpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       busy,
  output logic       map_en,
  output space_e     space,
  output logic       launch
);
  logic       armed;
  logic [2:0] arm_fields;
  logic [3:0] key;
  logic [2:0] fields;
  logic       take;
  logic       unused_bit;

  assign key        = ctl_wdata[7:4];
  assign fields     = ctl_wdata[3:1];
  assign unused_bit = ctl_wdata[0];
  assign take       = ctl_we && !busy;

  always_comb begin
    launch = take && armed && (key == KEY_GO) && (fields == arm_fields)
             && (space_e'(ctl_wdata[2:1]) != SP_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_en     <= 1'b0;
      space      <= SP_USER;
      armed      <= 1'b0;
      arm_fields <= '0;
    end else if (take) begin
      map_en <= ctl_wdata[3];
      space  <= space_e'(ctl_wdata[2:1]);
      armed  <= (key == KEY_ARM);
      if (key == KEY_ARM) arm_fields <= fields;
    end
  end

  // R4: after an accepted write that is not the arming step the lock is closed
  a_r4_disarm: assert property (@(posedge clk) disable iff (rst)
    (take && key != KEY_ARM) |=> !armed);
endmodule

// File: rtl/fpp_latch.sv
module fpp_latch #(
  parameter int PAGE_BYTES = 128,
  parameter int PG_AW      = 3,
  localparam int PAW       = $clog2(PAGE_BYTES),
  localparam int AW        = PAW + PG_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  input  logic [PAW-1:0]   rd_idx,
  input  logic             clear,
  output logic [PG_AW-1:0] page,
  output logic [7:0]       rd_byte,
  output logic             rd_loaded
);
  logic [7:0]            buf_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic                  accept;

  assign accept = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (accept) buf_mem[wr_addr[PAW-1:0]] <= wr_data;
    rd_byte <= buf_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded    <= '0;
      page      <= '0;
      rd_loaded <= 1'b0;
    end else begin
      rd_loaded <= loaded[rd_idx];
      if (clear) begin
        loaded <= '0;
      end else if (accept) begin
        loaded[wr_addr[PAW-1:0]] <= 1'b1;
        page <= wr_addr[AW-1:PAW];
      end
    end
  end

  // R12: marks do not move during programming until the final clear
  a_r12_marks_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !clear) |=> $stable(loaded));
  // R8: the clear at the end of programming empties every mark
  a_r8_marks_cleared: assert property (@(posedge clk) disable iff (rst)
    clear |=> (loaded == '0));
endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
  import fpp_pkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 200,
  localparam int PAW        = $clog2(PAGE_BYTES),
  localparam int EFF        = (PROG_CYCLES > PAGE_BYTES + 2) ? PROG_CYCLES : PAGE_BYTES + 2,
  localparam int CW         = $clog2(EFF + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           launch,
  input  space_e         space_in,
  output logic           busy,
  output space_e         prog_space,
  output logic [PAW-1:0] walk_idx,
  output logic           stage_v,
  output logic [PAW-1:0] stage_idx,
  output logic           done
);
  logic [CW-1:0] cnt;
  logic          in_range;

  assign walk_idx = cnt[PAW-1:0];
  assign in_range = (cnt < CW'(PAGE_BYTES));
  assign done     = busy && (cnt == CW'(EFF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt        <= '0;
      prog_space <= SP_USER;
      stage_v    <= 1'b0;
      stage_idx  <= '0;
    end else begin
      stage_v   <= busy && in_range;
      stage_idx <= walk_idx;
      if (!busy) begin
        cnt <= '0;
        if (launch) begin
          busy       <= 1'b1;
          prog_space <= space_in;
        end
      end else if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: busy only ends after the full programming window
  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == CW'(EFF - 1)));
endmodule

// File: rtl/fpp_array.sv
module fpp_array
  import fpp_pkg::*;
#(
  parameter int         PAGE_BYTES = 128,
  parameter int         PG_AW      = 3,
  parameter logic [7:0] FUSE_INIT  = 8'hFF,
  localparam int        PAW        = $clog2(PAGE_BYTES),
  localparam int        AW         = PAW + PG_AW,
  localparam int        DEPTH      = PAGE_BYTES << PG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          user_we,
  input  logic          xrow_we,
  input  logic          fuse_we,
  input  logic [AW-1:0] w_addr,
  input  logic [7:0]    w_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  space_e        rd_space,
  input  logic          busy,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);
  logic [7:0] user_mem [DEPTH];
  logic [7:0] xrow_mem [PAGE_BYTES];
  logic [7:0] fuse_q;
  logic [7:0] user_q, xrow_q;
  space_e     sp_q;
  logic       busy_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) user_mem[i] = 8'hFF;
    for (int i = 0; i < PAGE_BYTES; i++) xrow_mem[i] = 8'hFF;
    fuse_q = FUSE_INIT;
  end

  always_ff @(posedge clk) begin
    if (user_we) user_mem[w_addr] <= w_data;
    user_q <= user_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (xrow_we) xrow_mem[w_addr[PAW-1:0]] <= w_data;
    xrow_q <= xrow_mem[rd_addr[PAW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (fuse_we) fuse_q[7:4] <= w_data[7:4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sp_q     <= SP_USER;
      busy_q   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sp_q   <= rd_space;
        busy_q <= busy;
      end
    end
  end

  always_comb begin
    if (busy_q) rd_data = 8'hFF;
    else begin
      case (sp_q)
        SP_USER: rd_data = user_q;
        SP_XROW: rd_data = xrow_q;
        SP_FUSE: rd_data = fuse_q;
        default: rd_data = 8'hFF;
      endcase
    end
  end

  // R11: a read issued during programming returns the blank value next cycle
  a_r11_busy_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rd_valid && rd_data == 8'hFF));
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int         PAGE_BYTES  = 128,
  parameter int         NUM_PAGES   = 8,
  parameter int         PROG_CYCLES = 200,
  parameter logic [7:0] FUSE_INIT   = 8'hFF,
  localparam int        PAW         = $clog2(PAGE_BYTES),
  localparam int        PG_AW       = $clog2(NUM_PAGES),
  localparam int        AW          = PAW + PG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          lat_we,
  input  logic [AW-1:0] lat_addr,
  input  logic [7:0]    lat_wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);
  logic             map_en, launch, busy, done, stage_v, lat_loaded, commit;
  space_e           space, prog_space;
  logic [PAW-1:0]   walk_idx, stage_idx;
  logic [PG_AW-1:0] page;
  logic [7:0]       lat_byte;

  fpp_unlock u_unlock (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .busy(busy),
    .map_en(map_en), .space(space), .launch(launch)
  );

  fpp_seq #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .space_in(space), .busy(busy),
    .prog_space(prog_space), .walk_idx(walk_idx), .stage_v(stage_v),
    .stage_idx(stage_idx), .done(done)
  );

  fpp_latch #(.PAGE_BYTES(PAGE_BYTES), .PG_AW(PG_AW)) u_latch (
    .clk(clk), .rst(rst), .wr_en(lat_we && map_en), .wr_addr(lat_addr),
    .wr_data(lat_wdata), .busy(busy), .rd_idx(walk_idx), .clear(done),
    .page(page), .rd_byte(lat_byte), .rd_loaded(lat_loaded)
  );

  assign commit = stage_v && lat_loaded;

  fpp_array #(.PAGE_BYTES(PAGE_BYTES), .PG_AW(PG_AW), .FUSE_INIT(FUSE_INIT)) u_array (
    .clk(clk), .rst(rst),
    .user_we(commit && prog_space == SP_USER),
    .xrow_we(commit && prog_space == SP_XROW),
    .fuse_we(commit && prog_space == SP_FUSE && stage_idx == '0),
    .w_addr({page, stage_idx}), .w_data(lat_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_space(space), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign ctl_rdata = {4'b0000, map_en, space, busy};

  // R3: a completed unlock makes the controller busy on the next cycle
  a_r3_launch_busy: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);
  // R5: programming never runs against the null space
  a_r5_no_null_space: assert property (@(posedge clk) disable iff (rst)
    busy |-> (prog_space != SP_NONE));
endmodule

// File: tb/sim_flash_page_prog.sv
module sim_flash_page_prog;
  localparam int PB = 16, NP = 4, PC = 40, EFF = 40, AW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          ctl_we = 1'b0, lat_we = 1'b0, rd_en = 1'b0;
  logic [7:0]    ctl_wdata = '0, lat_wdata = '0;
  logic [AW-1:0] lat_addr = '0, rd_addr = '0;
  logic [7:0]    ctl_rdata, rd_data;
  logic          rd_valid;

  always #2 clk = ~clk;

  flash_page_prog #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .PROG_CYCLES(PC), .FUSE_INIT(8'hFF)) u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .lat_we(lat_we), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int         checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected rd_valid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic ctl_wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic lat_wr(input int pg, input int idx, input logic [7:0] d);
    @(negedge clk); lat_we = 1'b1; lat_addr = AW'(pg * PB + idx); lat_wdata = d;
    @(negedge clk); lat_we = 1'b0;
  endtask

  task automatic rd(input int pg, input int idx, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = AW'(pg * PB + idx);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctl_rdata[0] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic unlock(input logic [7:0] f);
    ctl_wr(8'h50 | f);
    ctl_wr(8'hA0 | f);
  endtask

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ctl_rdata == 8'h00, "R1 reset status", ctl_rdata, 8'h00);
    rd(0, 5, 8'hFF, "R1 blank user byte");

    // R2/R3/R6/R7: load bytes on page 2 then page 1, last page wins
    ctl_wr(8'h08);
    check(ctl_rdata == 8'h08, "R2 map bit set", ctl_rdata, 8'h08);
    lat_wr(2, 3, 8'h12);
    lat_wr(2, 15, 8'hA5);
    lat_wr(1, 0, 8'h3E);
    unlock(8'h08);
    check(ctl_rdata[0] == 1'b1, "R3 busy after unlock", ctl_rdata[0], 1);
    wait_idle(n);
    check(n == EFF, "R6 busy length", n, EFF);
    rd(1, 0, 8'h3E, "R2 byte 0 on last page");
    rd(1, 3, 8'h12, "R2 byte 3 on last page");
    rd(1, 15, 8'hA5, "R7 byte 15 on last page");
    rd(1, 1, 8'hFF, "R7 unloaded byte kept");
    rd(2, 3, 8'hFF, "R2 earlier page untouched");

    // R8: only the new byte is programmed on page 3
    lat_wr(3, 0, 8'h5A);
    unlock(8'h08);
    wait_idle(n);
    rd(3, 0, 8'h5A, "R8 new byte written");
    rd(3, 3, 8'hFF, "R8 stale mark not reused");
    rd(3, 15, 8'hFF, "R8 stale mark not reused hi");

    // R2: latch write with map clear ignored
    ctl_wr(8'h00);
    lat_wr(0, 2, 8'h33);
    ctl_wr(8'h08);
    lat_wr(0, 5, 8'h44);
    unlock(8'h08);
    wait_idle(n);
    rd(0, 2, 8'hFF, "R2 unmapped write dropped");
    rd(0, 5, 8'h44, "R2 mapped write kept");

    // R4: broken unlock sequences
    lat_wr(0, 6, 8'h66);
    ctl_wr(8'h58); ctl_wr(8'h08); ctl_wr(8'hA8);
    check(ctl_rdata[0] == 1'b0, "R4 interrupted sequence", ctl_rdata[0], 0);
    ctl_wr(8'hA8);
    check(ctl_rdata[0] == 1'b0, "R4 lone Ah key", ctl_rdata[0], 0);
    ctl_wr(8'h58); ctl_wr(8'hAA);
    check(ctl_rdata[0] == 1'b0, "R4 fields changed", ctl_rdata[0], 0);
    // R5: null space never launches
    unlock(8'h0E);
    check(ctl_rdata[0] == 1'b0, "R5 space 11 no launch", ctl_rdata[0], 0);
    ctl_wr(8'h08);
    rd(0, 6, 8'hFF, "R4 nothing programmed");
    unlock(8'h08);
    wait_idle(n);
    rd(0, 6, 8'h66, "R4 later valid unlock");

    // R9: extra row
    ctl_wr(8'h0A);
    lat_wr(0, 7, 8'h77);
    unlock(8'h0A);
    wait_idle(n);
    rd(0, 7, 8'h77, "R9 extra row byte");
    rd(0, 6, 8'hFF, "R9 extra row neighbour");
    ctl_wr(8'h06);
    rd(0, 7, 8'hFF, "R11 space 11 reads blank");
    ctl_wr(8'h08);
    rd(0, 7, 8'hFF, "R9 user array untouched");

    // R10: fuse byte, low nibble fixed
    ctl_wr(8'h0C);
    lat_wr(0, 0, 8'h3C);
    unlock(8'h0C);
    wait_idle(n);
    rd(0, 0, 8'h3F, "R10 fuse upper only");

    // R11/R12: traffic during busy
    ctl_wr(8'h08);
    lat_wr(0, 9, 8'h99);
    unlock(8'h08);
    lat_wr(0, 10, 8'hBB);
    rd(0, 9, 8'hFF, "R11 read during busy");
    ctl_wr(8'h00);
    check(ctl_rdata == 8'h09, "R12 control ignored while busy", ctl_rdata, 8'h09);
    wait_idle(n);
    rd(0, 9, 8'h99, "R12 launched byte");
    rd(0, 10, 8'hFF, "R12 busy latch write dropped");
    unlock(8'h08);
    wait_idle(n);
    rd(0, 10, 8'hFF, "R12 no mark from busy write");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule